// File: doc/BRIEF.md
# Die Thermal Protection Controller

This block watches a digital die-temperature reading, given in whole degrees Celsius together with a valid strobe, and turns it into three qualifiers for power sequencing. It works in phases. In the startup phase a low hysteresis pair, rising above 107 and falling below 102, stalls the power sequencer through a hold output. The register enables have no effect in this phase. Once the sequencer reports that startup is complete and no hold is pending, the block moves to the run phase. There a higher pair, rising above 115 and falling below 107, drives a sticky warning interrupt. A separate trip comparison above 140 can request a shutdown.

Both the warning and the shutdown are gated by enable levels, which a register file outside the block holds at zero by default. A shutdown request stays asserted until a sample falls below 102. The block then goes back to the startup phase, so the device can restart on its own after the die has cooled. All comparisons are strict and are made only on cycles where the strobe is high. Between samples the hysteresis state is held.

Top module: `thermprot_top`

## Requirements
- R1: After reset the block is in the startup phase and startup_hold, warn_irq and shdn_req are all low.
- R2: In the startup phase, a valid sample strictly above 107 raises startup_hold from the next cycle, whatever the enables are. A sample of exactly 107 does not raise it.
- R3: Once raised in the startup phase, startup_hold is released only by a valid sample strictly below 102. Samples from 102 to 107 keep it asserted.
- R4: With startup_done high, the block enters the run phase on the cycle in which the hold would be clear after that cycle's sample. It never enters while the hold remains. In the run phase startup_hold is low and the low threshold pair has no effect.
- R5: In the run phase, with warn_en high and the warning armed, a valid sample strictly above 115 sets warn_irq on the next cycle. A sample of exactly 115 does not set it, and no sample in the startup phase sets it.
- R6: warn_irq stays high until a cycle with warn_clr high clears it on the next cycle. When a set and a clear fall in the same cycle, the set wins.
- R7: After a sample above 115, the warning re-arms only once a valid sample falls strictly below 107. A sample of exactly 107 does not re-arm it. Each time the block enters the run phase, the warning starts armed.
- R8: A crossing above 115 while warn_en is low raises no interrupt but still disarms the warning. Raising warn_en afterwards does not set warn_irq until the temperature has first cooled below 107.
- R9: In the run phase, with shdn_en high, a valid sample strictly above 140 raises shdn_req, and also startup_hold, on the next cycle. With shdn_en low, or at exactly 140, there is no shutdown.
- R10: While shdn_req is high, startup_done is ignored and samples from 102 up keep the request. A valid sample strictly below 102 drops shdn_req and returns the block to the startup phase with the hold clear.
- R11: A cycle with temp_valid low changes no state, whatever value temp_code carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_valid | input | 1 | Strobe marking a new temperature sample |
| temp_code | input | TEMP_W | Die temperature, unsigned whole degrees Celsius |
| startup_done | input | 1 | Sequencer reports that startup is complete |
| warn_en | input | 1 | Enable for the run-phase warning interrupt |
| shdn_en | input | 1 | Enable for the over-temperature shutdown |
| warn_clr | input | 1 | Host clear for the warning flag |
| startup_hold | output | 1 | Stall request to the power sequencer |
| warn_irq | output | 1 | Sticky warning interrupt flag |
| shdn_req | output | 1 | Over-temperature shutdown request |

## Verification
Samples are placed on both sides of every threshold and exactly on each one: 107 and 102 in startup, 115 and 107 in the run phase, and 140 for the trip. This separates strict from non-strict comparisons and shows which pair is active in which phase. Non-strobed cycles carrying extreme codes show that state changes only on valid samples. Hot samples with the enables low, with a clear that coincides with a new crossing, and with startup_done high during shutdown separate gating and priority faults. A full trip, cool-down and re-entry cycle shows that the run pair starts armed again after a restart.

// File: rtl/thermprot_pkg.sv
package thermprot_pkg;
  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_RUN   = 2'd1,
    PH_SHDN  = 2'd2
  } phase_e;
endpackage

// File: rtl/thermprot_hyst.sv
module thermprot_hyst #(
  parameter int TEMP_W = 8,
  parameter int RISE   = 115,
  parameter int FALL   = 107
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              smp,
  input  logic [TEMP_W-1:0] temp,
  output logic              hot_o,
  output logic              hot_nxt_o,
  output logic              rise_o
);
  localparam logic [TEMP_W-1:0] RISE_C = TEMP_W'(RISE);
  localparam logic [TEMP_W-1:0] FALL_C = TEMP_W'(FALL);

  logic hot_q, hot_n, upd;
  logic above, below;

  assign above = temp > RISE_C;
  assign below = temp < FALL_C;

  always_comb begin
    hot_n = hot_q;
    upd   = !active || smp;
    if (!active)    hot_n = 1'b0;
    else if (smp) begin
      if (above)      hot_n = 1'b1;
      else if (below) hot_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hot_q <= 1'b0;
    else if (upd) hot_q <= hot_n;
  end

  assign hot_o     = hot_q;
  assign hot_nxt_o = hot_n;
  assign rise_o    = active && smp && !hot_q && above;

  p_hold_no_sample_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !smp) |=> (hot_o == $past(hot_o)));
  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && smp && temp > RISE_C) |=> hot_o);
  p_fall_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && smp && temp < FALL_C) |=> !hot_o);
endmodule

// File: rtl/thermprot_warn.sv
module thermprot_warn (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_n, upd;

  always_comb begin
    upd    = set_i || clr_i;
    flag_n = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (upd) flag_q <= flag_n;
  end

  assign flag_o = flag_q;

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/thermprot_top.sv
module thermprot_top #(
  parameter int TEMP_W     = 8,
  parameter int START_RISE = 107,
  parameter int START_FALL = 102,
  parameter int RUN_RISE   = 115,
  parameter int RUN_FALL   = 107,
  parameter int TRIP       = 140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              startup_done,
  input  logic              warn_en,
  input  logic              shdn_en,
  input  logic              warn_clr,
  output logic              startup_hold,
  output logic              warn_irq,
  output logic              shdn_req
);
  import thermprot_pkg::*;

  localparam logic [TEMP_W-1:0] TRIP_C    = TEMP_W'(TRIP);
  localparam logic [TEMP_W-1:0] RELEASE_C = TEMP_W'(START_FALL);

  phase_e phase_q, phase_n;
  logic   lo_hot, lo_nxt, lo_rise;
  logic   hi_hot, hi_nxt, hi_rise;
  logic   trip, cool;

  thermprot_hyst #(.TEMP_W(TEMP_W), .RISE(START_RISE), .FALL(START_FALL)) u_lo (
    .clk(clk), .rst_n(rst_n), .active(phase_q == PH_START), .smp(temp_valid),
    .temp(temp_code), .hot_o(lo_hot), .hot_nxt_o(lo_nxt), .rise_o(lo_rise));

  thermprot_hyst #(.TEMP_W(TEMP_W), .RISE(RUN_RISE), .FALL(RUN_FALL)) u_hi (
    .clk(clk), .rst_n(rst_n), .active(phase_q == PH_RUN), .smp(temp_valid),
    .temp(temp_code), .hot_o(hi_hot), .hot_nxt_o(hi_nxt), .rise_o(hi_rise));

  thermprot_warn u_warn (
    .clk(clk), .rst_n(rst_n), .set_i(hi_rise && warn_en), .clr_i(warn_clr),
    .flag_o(warn_irq));

  assign trip = temp_valid && (temp_code > TRIP_C);
  assign cool = temp_valid && (temp_code < RELEASE_C);

  always_comb begin
    phase_n = phase_q;
    case (phase_q)
      PH_START: if (startup_done && !lo_nxt) phase_n = PH_RUN;
      PH_RUN:   if (shdn_en && trip)         phase_n = PH_SHDN;
      PH_SHDN:  if (cool)                    phase_n = PH_START;
      default:                               phase_n = PH_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_START;
    else        phase_q <= phase_n;
  end

  assign startup_hold = (phase_q == PH_SHDN) || ((phase_q == PH_START) && lo_hot);
  assign shdn_req     = (phase_q == PH_SHDN);

  p_trip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN && shdn_en && trip) |=> (shdn_req && startup_hold));
  p_no_trip_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_req && !shdn_en) |=> !shdn_req);
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_req && cool) |=> (!shdn_req && !startup_hold));
  p_shdn_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_req && !cool) |=> shdn_req);
  p_no_warn_startup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_RUN && !warn_irq) |=> !warn_irq);
endmodule

// File: tb/thermprot_top_bench.sv
module thermprot_top_bench;
  typedef struct {
    logic  h;
    logic  w;
    logic  s;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       temp_valid, startup_done, warn_en, shdn_en, warn_clr;
  logic [7:0] temp_code;
  logic       startup_hold, warn_irq, shdn_req;

  logic g_done = 1'b0, g_wen = 1'b0, g_sen = 1'b0, g_clr = 1'b0;

  exp_t exp_q[$];
  int   checks = 0, failures = 0, cyc_cnt = 0;
  bit   done_flag = 1'b0;

  always #4 clk = ~clk;

  thermprot_top u_thermprot_top (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_code(temp_code),
    .startup_done(startup_done), .warn_en(warn_en), .shdn_en(shdn_en),
    .warn_clr(warn_clr), .startup_hold(startup_hold), .warn_irq(warn_irq),
    .shdn_req(shdn_req));

  task automatic compare(exp_t e);
    checks++;
    if (startup_hold !== e.h || warn_irq !== e.w || shdn_req !== e.s) begin
      failures++;
      $display("FAIL %s: got hold=%b warn=%b shdn=%b expected hold=%b warn=%b shdn=%b",
               e.tag, startup_hold, warn_irq, shdn_req, e.h, e.w, e.s);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the result due after the edge
  task automatic cyc(input logic v, input logic [7:0] t,
                     input logic h, input logic w, input logic s, input string tag);
    exp_t e;
    @(negedge clk);
    temp_valid   = v;
    temp_code    = t;
    startup_done = g_done;
    warn_en      = g_wen;
    shdn_en      = g_sen;
    warn_clr     = g_clr;
    e.h = h; e.w = w; e.s = s; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) compare(exp_q.pop_front());
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000 && !done_flag) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    exp_t e;
    rst_n = 1'b0; temp_valid = 1'b0; temp_code = 8'd0;
    startup_done = 1'b0; warn_en = 1'b0; shdn_en = 1'b0; warn_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    e.h = 1'b0; e.w = 1'b0; e.s = 1'b0; e.tag = "R1 reset state";
    compare(e);
    rst_n = 1'b1;

    cyc(1, 8'd100, 0, 0, 0, "R2 below rise");
    cyc(1, 8'd107, 0, 0, 0, "R2 at 107 no hold");
    cyc(1, 8'd108, 1, 0, 0, "R2 above 107 holds");
    cyc(0, 8'd50,  1, 0, 0, "R11 no strobe keeps hold");
    cyc(1, 8'd104, 1, 0, 0, "R3 104 keeps hold");
    cyc(1, 8'd102, 1, 0, 0, "R3 102 keeps hold");
    g_done = 1'b1;
    cyc(1, 8'd103, 1, 0, 0, "R4 no run entry while held");
    cyc(0, 8'd0,   1, 0, 0, "R11 no strobe with done");
    cyc(1, 8'd101, 0, 0, 0, "R3 R4 release and enter run");
    cyc(1, 8'd110, 0, 0, 0, "R4 low pair unused in run");
    cyc(1, 8'd115, 0, 0, 0, "R5 at 115 no warn");
    cyc(1, 8'd116, 0, 0, 0, "R8 disabled crossing");
    g_wen = 1'b1;
    cyc(1, 8'd120, 0, 0, 0, "R8 still disarmed");
    cyc(1, 8'd107, 0, 0, 0, "R7 107 does not rearm");
    cyc(1, 8'd106, 0, 0, 0, "R7 rearm");
    cyc(1, 8'd116, 0, 1, 0, "R5 warning set");
    cyc(0, 8'd50,  0, 1, 0, "R6 sticky");
    g_clr = 1'b1;
    cyc(1, 8'd118, 0, 0, 0, "R6 clear");
    g_clr = 1'b0;
    cyc(1, 8'd117, 0, 0, 0, "R7 no reraise without cooling");
    cyc(1, 8'd100, 0, 0, 0, "R7 cool rearm");
    g_clr = 1'b1;
    cyc(1, 8'd116, 0, 1, 0, "R6 set wins over clear");
    cyc(0, 8'd0,   0, 0, 0, "R6 clear pulse");
    g_clr = 1'b0;
    cyc(1, 8'd150, 0, 0, 0, "R9 shutdown disabled");
    g_sen = 1'b1;
    cyc(1, 8'd140, 0, 0, 0, "R9 at 140 no trip");
    cyc(1, 8'd141, 1, 0, 1, "R9 trip");
    cyc(1, 8'd102, 1, 0, 1, "R10 102 keeps shutdown with done high");
    cyc(0, 8'd90,  1, 0, 1, "R11 no strobe in shutdown");
    g_done = 1'b0;
    cyc(1, 8'd101, 0, 0, 0, "R10 release to startup");
    cyc(1, 8'd120, 1, 0, 0, "R10 R5 startup pair again, no warn");
    cyc(1, 8'd90,  0, 0, 0, "R3 release after restart");
    g_done = 1'b1;
    cyc(0, 8'd0,   0, 0, 0, "R4 run entry after restart");
    cyc(1, 8'd116, 0, 1, 0, "R7 armed after re-entry");

    @(negedge clk);
    @(negedge clk);
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule